// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits next to the bit engine of an I2C master and decides, cycle by cycle, whether that master may still drive the bus. It watches the raw SCL and SDA lines through a synchronizer. From the START and STOP conditions it sees, it keeps a bus-busy state. It also counts the bits of the current transfer so it can report whether the transfer is still in its address part or has moved on to data.

The master asks to begin a transfer with `start_req`. The request is granted only while the bus is idle, so the engine holds off for as long as the grant stays low. Once granted, the monitor compares the level the engine intends to put on SDA with the level seen on the line, once per bit, when synchronized SCL rises. The comparison covers the address bits and, if both contenders agree there, the data bits as well. A master loses when it leaves SDA released (1) while the line reads 0. On a loss the SDA output-enable permission is withdrawn at once and a sticky flag plus a one-cycle event pulse are raised. The monitor keeps tracking the bus and permits nothing until it sees the STOP that returns the bus to idle.

All pins are plain control and status levels. There is no streaming data path and so no valid/ready handshake.

Top module: `i2c_arb_monitor`

## Requirements
- R1: `start_grant` is high exactly when `start_req` is high, `bus_busy` is low and the monitor does not already own or hold a lost transfer. A request made while `bus_busy` is high gets no grant and leaves `sda_oe_allow` low.
- R2: SCL and SDA pass through a two-flop synchronizer. On the synchronized lines, SDA falling while SCL stays high sets `bus_busy`, and SDA rising while SCL stays high clears it.
- R3: Intended and observed SDA are compared only in the cycle where synchronized SCL rises. An SDA mismatch during the SCL-low phase is ignored.
- R4: A loss is detected when `sda_drive` is 1 (released) and the synchronized SDA is 0 at that comparison point. Matching levels never cause a loss.
- R5: `sda_oe_allow` is high only while this master owns the transfer. It goes low in the same cycle that `arb_lost` rises and stays low until a STOP has been seen.
- R6: `arb_lost` is set by a loss and holds, across the STOP, until `lost_clr` is pulsed. A loss in the same cycle as a clear wins.
- R7: `arb_lost_irq` is high for exactly one cycle per loss, in the cycle `arb_lost` becomes set.
- R8: Two masters that both issue START inside the synchronizer latency are both granted and go on. Only the bitwise comparison decides between them.
- R9: `addr_phase` is high while the bus is busy and fewer than ADDR_BITS (default 8) SCL rises have passed since the last START. Comparison continues unchanged into the data bits after that, so a loss can also occur in the data phase.
- R10: A master that lost keeps tracking START/STOP. After the STOP it can be granted a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_drive | input | 1 | SDA level the bit engine intends (1 = released) |
| start_req | input | 1 | Request to begin a transfer |
| lost_clr | input | 1 | Pulse to clear the sticky loss flag |
| start_grant | output | 1 | Permission to issue START this cycle |
| bus_busy | output | 1 | Bus between START and STOP |
| addr_phase | output | 1 | Transfer still in its address bits |
| sda_oe_allow | output | 1 | Engine may enable its SDA driver |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| arb_lost_irq | output | 1 | One-cycle pulse on each loss |

## Verification
The bench models two masters on a wired-AND line and predicts the losing bit from the first position where own is 1 and the rival is 0. The same rule covers address-phase losses, data-phase losses after identical addresses, and clean wins. It pulls SDA low during an SCL-low phase, which a design comparing at every cycle would report as a false loss. It raises a request together with a rival START, where a design gating the grant on the raw line would wrongly refuse. It requests while another master holds the bus, where a leaky grant would let two STARTs collide. It also checks that the loss flag survives the STOP, that the output-enable permission stays off until that STOP, and that the event pulse never lasts two cycles.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE   = 2'd0,
    OWN_ACTIVE = 2'd1,
    OWN_LOST   = 2'd2
  } own_state_t;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES < 2) begin : g_single
      logic [WIDTH-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RESET_VAL;
        else        q_r <= d;
      end
      assign q = q_r;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_bus_tracker.sv
module i2c_bus_tracker
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bus_lines_t lines,
  output logic       start_det,
  output logic       stop_det,
  output logic       scl_rise,
  output logic       bus_busy,
  output logic       addr_phase
);
  localparam int CNT_W = $clog2(ADDR_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ADDR_BITS);

  bus_lines_t       prev;
  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '{scl: 1'b1, sda: 1'b1};
    else        prev <= lines;
  end

  assign start_det = lines.scl & prev.scl & prev.sda & ~lines.sda;
  assign stop_det  = lines.scl & prev.scl & ~prev.sda & lines.sda;
  assign scl_rise  = lines.scl & ~prev.scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
    else if (stop_det)  bus_busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bit_cnt <= '0;
    else if (start_det)
      bit_cnt <= '0;
    else if (scl_rise && bus_busy && bit_cnt < CNT_MAX)
      bit_cnt <= bit_cnt + CNT_W'(1);
  end

  assign addr_phase = bus_busy & (bit_cnt < CNT_MAX);
endmodule

// File: rtl/i2c_arb_core.sv
module i2c_arb_core
  import i2c_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic sda_drive,
  input  logic sda_seen,
  input  logic scl_rise,
  input  logic stop_det,
  input  logic bus_busy,
  input  logic lost_clr,
  output logic start_grant,
  output logic sda_oe_allow,
  output logic arb_lost,
  output logic arb_lost_irq
);
  own_state_t state, state_nx;
  logic       lost_event;

  assign start_grant = start_req & ~bus_busy & (state == OWN_IDLE);
  assign lost_event  = (state == OWN_ACTIVE) & scl_rise & sda_drive & ~sda_seen;

  always_comb begin
    state_nx = state;
    case (state)
      OWN_IDLE:   if (start_grant) state_nx = OWN_ACTIVE;
      OWN_ACTIVE: if (lost_event)  state_nx = OWN_LOST;
                  else if (stop_det) state_nx = OWN_IDLE;
      OWN_LOST:   if (stop_det)    state_nx = OWN_IDLE;
      default:    state_nx = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OWN_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost     <= 1'b0;
      arb_lost_irq <= 1'b0;
    end else begin
      arb_lost_irq <= lost_event;
      if (lost_event)    arb_lost <= 1'b1;
      else if (lost_clr) arb_lost <= 1'b0;
    end
  end

  assign sda_oe_allow = (state == OWN_ACTIVE);
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_drive,
  input  logic start_req,
  input  logic lost_clr,
  output logic start_grant,
  output logic bus_busy,
  output logic addr_phase,
  output logic sda_oe_allow,
  output logic arb_lost,
  output logic arb_lost_irq
);
  bus_lines_t synced;
  logic       start_det, stop_det, scl_rise;

  i2c_line_sync #(
    .WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(synced)
  );

  i2c_bus_tracker #(.ADDR_BITS(ADDR_BITS)) u_track (
    .clk(clk), .rst_n(rst_n), .lines(synced),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise),
    .bus_busy(bus_busy), .addr_phase(addr_phase)
  );

  i2c_arb_core u_core (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .sda_drive(sda_drive), .sda_seen(synced.sda), .scl_rise(scl_rise),
    .stop_det(stop_det), .bus_busy(bus_busy), .lost_clr(lost_clr),
    .start_grant(start_grant), .sda_oe_allow(sda_oe_allow),
    .arb_lost(arb_lost), .arb_lost_irq(arb_lost_irq)
  );
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic lost_clr,
  input logic start_grant,
  input logic bus_busy,
  input logic sda_oe_allow,
  input logic arb_lost,
  input logic arb_lost_irq
);
  // R1
  grant_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !start_grant);

  // R5
  oe_drop_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !sda_oe_allow);

  // R5
  passive_until_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sda_oe_allow && bus_busy) |=> !sda_oe_allow);

  // R6
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !lost_clr) |=> arb_lost);

  // R7
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_irq |=> !arb_lost_irq);

  // R7
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_irq |-> arb_lost);
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk u_chk (.*);

// File: tb/test_i2c_arb_monitor.sv
module test_i2c_arb_monitor;
  localparam int ADDR_BITS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, sda_drive = 1'b1;
  logic start_req = 1'b0, lost_clr = 1'b0;
  logic start_grant, bus_busy, addr_phase, sda_oe_allow, arb_lost, arb_lost_irq;

  int n_vec = 0, n_bad = 0;
  int irq_seen = 0, irq_wide = 0;
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_arb_monitor #(.ADDR_BITS(ADDR_BITS)) i_i2c_arb_monitor (.*);

  always @(negedge clk) begin
    if (arb_lost_irq) irq_seen++;
    if (arb_lost_irq && irq_prev) irq_wide++;
    irq_prev = arb_lost_irq;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic bit loses(input bit own_bit, input bit line);
    return own_bit && !line;
  endfunction

  task automatic run_xfer(input logic [15:0] own, input logic [15:0] oth,
                          input bit rival_first, input bit low_glitch);
    bit lost_m = 0;
    int irq0 = irq_seen;
    @(negedge clk);
    start_req = 1'b1;
    if (rival_first) sda_in = 1'b0;
    #1 chk(rival_first ? "R8 grant with rival START" : "R1 grant idle", 32'(start_grant), 1);
    @(negedge clk);
    start_req = 1'b0;
    chk("R1 oe allowed after grant", 32'(sda_oe_allow), 1);
    sda_drive = 1'b0; sda_in = 1'b0;
    settle();
    chk("R2 busy after START", 32'(bus_busy), 1);
    scl_in = 1'b0;
    settle();
    for (int i = 0; i < 16; i++) begin
      bit o = own[15-i];
      bit t = oth[15-i];
      bit line = (lost_m ? 1'b1 : o) & t;
      sda_drive = o;
      if (low_glitch && i == 2) begin
        sda_in = 1'b0;
        settle();
      end
      sda_in = line;
      settle();
      if (i == 0) chk("R9 addr phase at first bit", 32'(addr_phase), 1);
      if (i == ADDR_BITS) chk("R9 data phase after address", 32'(addr_phase), 0);
      scl_in = 1'b1;
      settle();
      if (!lost_m && loses(o, line)) lost_m = 1;
      chk(low_glitch ? "R3 compare at SCL high only" : "R4 loss detect", 32'(arb_lost), 32'(lost_m));
      chk("R5 oe permission", 32'(sda_oe_allow), 32'(!lost_m));
      scl_in = 1'b0;
      settle();
    end
    sda_drive = 1'b0; sda_in = 1'b0;
    settle();
    scl_in = 1'b1;
    settle();
    chk("R5 passive until STOP", 32'(sda_oe_allow), 32'(!lost_m));
    sda_drive = 1'b1; sda_in = 1'b1;
    settle();
    chk("R2 idle after STOP", 32'(bus_busy), 0);
    chk("R10 no ownership after STOP", 32'(sda_oe_allow), 0);
    chk("R6 flag held over STOP", 32'(arb_lost), 32'(lost_m));
    chk("R7 one pulse per loss", 32'(irq_seen - irq0), 32'(lost_m));
    lost_clr = 1'b1;
    @(negedge clk);
    lost_clr = 1'b0;
    settle();
    chk("R6 flag cleared", 32'(arb_lost), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset grant", 32'(start_grant), 0);
    chk("R2 reset idle", 32'(bus_busy), 0);
    chk("R5 reset oe", 32'(sda_oe_allow), 0);
    chk("R6 reset flag", 32'(arb_lost), 0);
    rst_n = 1'b1;
    settle();

    // R1: a different master owns the bus, our request is held off
    sda_in = 1'b0;
    settle();
    chk("R2 busy on foreign START", 32'(bus_busy), 1);
    start_req = 1'b1;
    #1 chk("R1 no grant while busy", 32'(start_grant), 0);
    settle();
    chk("R1 oe stays off while busy", 32'(sda_oe_allow), 0);
    start_req = 1'b0;
    scl_in = 1'b0; settle();
    scl_in = 1'b1; settle();
    sda_in = 1'b1; settle();
    chk("R2 idle after foreign STOP", 32'(bus_busy), 0);

    run_xfer(16'hA55A, 16'hA55A, 1'b0, 1'b0);   // clean win
    run_xfer(16'hC300, 16'h8300, 1'b0, 1'b0);   // R9 address-phase loss
    run_xfer(16'hA5F0, 16'hA5E0, 1'b0, 1'b0);   // R9 data-phase loss
    run_xfer(16'h3C3C, 16'h3C3C, 1'b0, 1'b1);   // R3 low-phase glitch
    run_xfer(16'hFFFF, 16'h7FFF, 1'b1, 1'b0);   // R8 simultaneous START
    run_xfer(16'h0F0F, 16'h0F0F, 1'b0, 1'b0);   // R10 new grant after loss
    for (int k = 0; k < 20; k++) begin
      logic [15:0] a = 16'($urandom());
      logic [15:0] b = (k % 3 == 0) ? {a[15:8], 8'($urandom())} : 16'($urandom());
      run_xfer(a, b, 1'($urandom() & 1), 1'b0);
    end
    chk("R7 pulse never wider than one cycle", 32'(irq_wide), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule